// File: doc/BRIEF.md
# Block-Device Command Descriptor Walker

This block runs one queued disk command end to end for a single channel. Software leaves a queue of 32 command descriptors in memory. Each descriptor points to a 4 KB command table. The table starts with a 128-byte header that carries the 48-bit starting block address. A scatter-gather array of buffer descriptors follows the header.

On a start pulse with a slot index, the walker fetches the fields of that slot's descriptor and rebuilds the block address from the header. It then visits each buffer descriptor in turn. For every buffer it hands a segment request (64-bit address, byte count, direction) to a downstream DMA engine. It then cuts that buffer into bursts of a fixed configured size.

After the last buffer, the walker writes the summed byte count back into the descriptor. It pulses done once that write is acknowledged. A malformed buffer count ends the command early: done is raised with an error flag, and no segment is issued.

All memory access goes through a 32-bit word port that carries one request at a time. The request is held until it is acknowledged.

Top module: `cmd_walker`

## Requirements
- R1: The descriptor of slot k is read at (list base with its low 4 bits forced to zero) + 16*k, at word offsets 0, 8 and 12. Low base bits set to one change no address.
- R2: Bit 6 of descriptor word 0 selects the direction: 1 means memory to device (write), 0 means device to memory (read). The direction appears on `seg_write_o` and `burst_write_o`. The other flag bits have no effect.
- R3: The buffer count is descriptor word 0 bits 31:16. A count of 0, or of more than 248, ends the command with `done_o` and `err_o` high. No segment or burst is emitted and no write-back occurs. A count of 248 is processed normally.
- R4: The 48-bit block address on `lba_o` is table word 8 bits 23:0 (upper 24 bits) joined to table word 4 bits 23:0 (lower 24 bits). Bits 31:24 of both words are ignored.
- R5: Buffer i is described at table + 128 + 16*i: low address at +0, high address at +4, byte count at +12. Its segment carries exactly that address and count.
- R6: A buffer is split into bursts that start at its address and follow each other contiguously. Each burst is BURST_BYTES long except a shorter final burst. The lengths sum to the byte count, and a zero count gives no bursts.
- R7: Segments are issued in buffer order. No segment is offered while a burst is pending, and a buffer's bursts all complete before the next buffer is fetched.
- R8: After the last buffer, the 32-bit sum of all byte counts is written to descriptor offset 4 (mem_we_o high).
- R9: `done_o` is a one-cycle pulse that follows the acknowledge of the write-back (or of the aborting read). `busy_o` is high from the cycle after start until done. A start pulse while busy is ignored.
- R10: A memory request keeps its address, write enable and data unchanged until `mem_ack_i`. A segment or burst offer keeps its contents until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command (taken when idle) |
| slot_i | input | 5 | Descriptor slot index |
| list_base_i | input | 64 | Command queue base byte address |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Last command aborted on bad buffer count |
| lba_o | output | 48 | Recovered starting block address |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| seg_valid_o | output | 1 | Segment request offered |
| seg_ready_i | input | 1 | Segment accepted |
| seg_addr_o | output | 64 | Segment buffer address |
| seg_len_o | output | 32 | Segment byte count |
| seg_write_o | output | 1 | Segment direction (1 = memory to device) |
| burst_valid_o | output | 1 | Burst offered |
| burst_ready_i | input | 1 | Burst accepted |
| burst_addr_o | output | 64 | Burst start address |
| burst_len_o | output | 7 | Burst byte length (width log2(BURST_BYTES)+1) |
| burst_write_o | output | 1 | Burst direction |

## Verification
Some behaviours are checked by assertions on every cycle. These are the handshake stability of memory requests, segments and bursts, and the rule that a segment and a burst are never offered together. The assertions also check burst length bounds and the contiguity of consecutive bursts. They further check that done is a single pulse after an acknowledge, and that an error never coexists with a segment or burst offer.

Other behaviours need the bench's scenarios. These are the address arithmetic of descriptor, header and buffer fetches, block address assembly, direction decoding and the written-back sum. The same holds for the abort limits at 0, 248 and 249 buffers and for the ignored start pulse. The bench sweeps slot, buffer count and direction against expectations it computes itself.

// File: rtl/cmd_walker_pkg.sv
package cmd_walker_pkg;
  localparam int ADDR_W      = 64;
  localparam int WORD_W      = 32;
  localparam int LBA_W       = 48;
  localparam int DESC_BYTES  = 16;
  localparam int HDR_BYTES   = 128;
  localparam int BUFD_BYTES  = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_HDR, S_BUF, S_ISSUE, S_WB, S_DONE
  } cw_state_e;

  // block address is scattered over two header words, 24 bits each
  function automatic logic [LBA_W-1:0] lba_join(input logic [WORD_W-1:0] lo_w,
                                                input logic [WORD_W-1:0] hi_w);
    return {hi_w[23:0], lo_w[23:0]};
  endfunction
endpackage

// File: rtl/cw_addr_gen.sv
module cw_addr_gen
  import cmd_walker_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int BIDX_W = 8
) (
  input  cw_state_e          state_i,
  input  logic [1:0]         widx_i,
  input  logic [ADDR_W-1:0]  list_base_i,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [ADDR_W-1:0]  tbl_i,
  input  logic [BIDX_W-1:0]  buf_idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int DSH = $clog2(DESC_BYTES);
  localparam int BSH = $clog2(BUFD_BYTES);

  logic [ADDR_W-1:0] desc_a, buf_a;
  logic [ADDR_W-1:0] desc_off, buf_off;

  assign desc_a = list_base_i + (ADDR_W'(slot_i) << DSH);
  assign buf_a  = tbl_i + ADDR_W'(HDR_BYTES) + (ADDR_W'(buf_idx_i) << BSH);

  always_comb begin
    case (widx_i)
      2'd0:    desc_off = ADDR_W'(0);
      2'd1:    desc_off = ADDR_W'(8);   // table address low
      default: desc_off = ADDR_W'(12);  // table address high
    endcase
    case (widx_i)
      2'd0:    buf_off = ADDR_W'(0);
      2'd1:    buf_off = ADDR_W'(4);
      default: buf_off = ADDR_W'(12);   // byte count, skips reserved word
    endcase
  end

  always_comb begin
    case (state_i)
      S_DESC:  addr_o = desc_a + desc_off;
      S_HDR:   addr_o = tbl_i + ADDR_W'(4) + (ADDR_W'(widx_i) << 2);
      S_BUF:   addr_o = buf_a + buf_off;
      S_WB:    addr_o = desc_a + ADDR_W'(4);
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/cw_burst_split.sv
module cw_burst_split #(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int BURST_BYTES = 64,
  localparam int BL_W       = $clog2(BURST_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              write_i,
  output logic              busy_o,
  output logic              burst_valid_o,
  input  logic              burst_ready_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic [BL_W-1:0]   burst_len_o,
  output logic              burst_write_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              write_q, busy_q;
  logic              at_tail;
  logic [BL_W-1:0]   step;

  assign at_tail = rem_q <= LEN_W'(BURST_BYTES);
  assign step    = at_tail ? BL_W'(rem_q) : BL_W'(BURST_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rem_q   <= '0;
      write_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      addr_q  <= addr_i;
      rem_q   <= len_i;
      write_q <= write_i;
      busy_q  <= len_i != '0;
    end else if (busy_q && burst_ready_i) begin
      addr_q <= addr_q + ADDR_W'(step);
      rem_q  <= rem_q - LEN_W'(step);
      if (at_tail) busy_q <= 1'b0;
    end
  end

  assign busy_o        = busy_q;
  assign burst_valid_o = busy_q;
  assign burst_addr_o  = addr_q;
  assign burst_len_o   = step;
  assign burst_write_o = write_q;
endmodule

// File: rtl/cmd_walker.sv
module cmd_walker
  import cmd_walker_pkg::*;
#(
  parameter int BURST_BYTES = 64,
  parameter int N_SLOTS     = 32,
  parameter int BUF_MAX     = 248,
  parameter int CNT_W       = 32,
  localparam int SLOT_W     = $clog2(N_SLOTS),
  localparam int BIDX_W     = $clog2(BUF_MAX + 1),
  localparam int BL_W       = $clog2(BURST_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [63:0]       list_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [47:0]       lba_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              seg_valid_o,
  input  logic              seg_ready_i,
  output logic [63:0]       seg_addr_o,
  output logic [CNT_W-1:0]  seg_len_o,
  output logic              seg_write_o,
  output logic              burst_valid_o,
  input  logic              burst_ready_i,
  output logic [63:0]       burst_addr_o,
  output logic [BL_W-1:0]   burst_len_o,
  output logic              burst_write_o
);
  cw_state_e          state_q;
  logic [1:0]         widx_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [ADDR_W-1:0]  base_q, tbl_q, baddr_q;
  logic [15:0]        nbuf_q;
  logic [BIDX_W-1:0]  bidx_q;
  logic [CNT_W-1:0]   blen_q, total_q;
  logic [23:0]        lba_lo_q;
  logic [LBA_W-1:0]   lba_q;
  logic               write_q, err_q, seg_sent_q;

  logic               split_busy, seg_take, advance, last_buf, bad_cnt;
  logic [15:0]        cnt_in;

  assign cnt_in   = mem_rdata_i[31:16];
  assign bad_cnt  = (cnt_in == 16'd0) || (cnt_in > 16'(BUF_MAX));
  assign seg_take = seg_valid_o && seg_ready_i;
  assign advance  = (state_q == S_ISSUE) && seg_sent_q && !split_busy;
  assign last_buf = (BIDX_W'(bidx_q + 1'b1) == BIDX_W'(nbuf_q));

  cw_addr_gen #(.SLOT_W(SLOT_W), .BIDX_W(BIDX_W)) u_addr (
    .state_i     (state_q),
    .widx_i      (widx_q),
    .list_base_i (base_q),
    .slot_i      (slot_q),
    .tbl_i       (tbl_q),
    .buf_idx_i   (bidx_q),
    .addr_o      (mem_addr_o)
  );

  cw_burst_split #(.ADDR_W(ADDR_W), .LEN_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_split (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (seg_take),
    .addr_i        (baddr_q),
    .len_i         (blen_q),
    .write_i       (write_q),
    .busy_o        (split_busy),
    .burst_valid_o (burst_valid_o),
    .burst_ready_i (burst_ready_i),
    .burst_addr_o  (burst_addr_o),
    .burst_len_o   (burst_len_o),
    .burst_write_o (burst_write_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      widx_q     <= '0;
      slot_q     <= '0;
      base_q     <= '0;
      tbl_q      <= '0;
      baddr_q    <= '0;
      nbuf_q     <= '0;
      bidx_q     <= '0;
      blen_q     <= '0;
      total_q    <= '0;
      lba_lo_q   <= '0;
      lba_q      <= '0;
      write_q    <= 1'b0;
      err_q      <= 1'b0;
      seg_sent_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          slot_q  <= slot_i;
          base_q  <= list_base_i & ~ADDR_W'(DESC_BYTES - 1);
          err_q   <= 1'b0;
          total_q <= '0;
          widx_q  <= '0;
          state_q <= S_DESC;
        end
        S_DESC: if (mem_ack_i) begin
          case (widx_q)
            2'd0: begin
              write_q <= mem_rdata_i[6];
              nbuf_q  <= cnt_in;
              if (bad_cnt) begin
                err_q   <= 1'b1;
                state_q <= S_DONE;
              end else begin
                widx_q <= 2'd1;
              end
            end
            2'd1: begin
              tbl_q[31:0] <= mem_rdata_i;
              widx_q      <= 2'd2;
            end
            default: begin
              tbl_q[63:32] <= mem_rdata_i;
              widx_q       <= '0;
              state_q      <= S_HDR;
            end
          endcase
        end
        S_HDR: if (mem_ack_i) begin
          if (widx_q == 2'd0) begin
            lba_lo_q <= mem_rdata_i[23:0];
            widx_q   <= 2'd1;
          end else begin
            lba_q   <= lba_join({8'h00, lba_lo_q}, mem_rdata_i);
            widx_q  <= '0;
            bidx_q  <= '0;
            state_q <= S_BUF;
          end
        end
        S_BUF: if (mem_ack_i) begin
          case (widx_q)
            2'd0: begin
              baddr_q[31:0] <= mem_rdata_i;
              widx_q        <= 2'd1;
            end
            2'd1: begin
              baddr_q[63:32] <= mem_rdata_i;
              widx_q         <= 2'd2;
            end
            default: begin
              blen_q     <= mem_rdata_i;
              widx_q     <= '0;
              seg_sent_q <= 1'b0;
              state_q    <= S_ISSUE;
            end
          endcase
        end
        S_ISSUE: begin
          if (seg_take) seg_sent_q <= 1'b1;
          if (advance) begin
            total_q <= total_q + blen_q;
            bidx_q  <= bidx_q + 1'b1;
            state_q <= last_buf ? S_WB : S_BUF;
          end
        end
        S_WB:    if (mem_ack_i) state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = state_q == S_DONE;
  assign err_o       = err_q;
  assign lba_o       = lba_q;
  assign mem_req_o   = (state_q == S_DESC) || (state_q == S_HDR) ||
                       (state_q == S_BUF)  || (state_q == S_WB);
  assign mem_we_o    = state_q == S_WB;
  assign mem_wdata_o = total_q;
  assign seg_valid_o = (state_q == S_ISSUE) && !seg_sent_q;
  assign seg_addr_o  = baddr_q;
  assign seg_len_o   = blen_q;
  assign seg_write_o = write_q;
endmodule

// File: rtl/cmd_walker_chk.sv
module cmd_walker_chk #(
  parameter int BURST_BYTES = 64,
  parameter int CNT_W       = 32,
  localparam int BL_W       = $clog2(BURST_BYTES) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [63:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_ack_i,
  input logic             seg_valid_o,
  input logic             seg_ready_i,
  input logic [63:0]      seg_addr_o,
  input logic [CNT_W-1:0] seg_len_o,
  input logic             burst_valid_o,
  input logic             burst_ready_i,
  input logic [63:0]      burst_addr_o,
  input logic [BL_W-1:0]  burst_len_o
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  p_seg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o));

  p_burst_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && !burst_ready_i |=> burst_valid_o && $stable(burst_addr_o) &&
                                        $stable(burst_len_o));

  p_burst_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o |-> (burst_len_o != '0) && (burst_len_o <= BL_W'(BURST_BYTES)));

  p_burst_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_valid_o && burst_ready_i |=>
      !burst_valid_o || (burst_addr_o == $past(burst_addr_o) + 64'($past(burst_len_o))));

  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(seg_valid_o && burst_valid_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o && $past(mem_ack_i));

  p_done_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> $past(mem_we_o && mem_req_o));

  p_err_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !seg_valid_o && !burst_valid_o && !mem_we_o);
endmodule

bind cmd_walker cmd_walker_chk #(.BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .done_o        (done_o),
  .err_o         (err_o),
  .busy_o        (busy_o),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .mem_ack_i     (mem_ack_i),
  .seg_valid_o   (seg_valid_o),
  .seg_ready_i   (seg_ready_i),
  .seg_addr_o    (seg_addr_o),
  .seg_len_o     (seg_len_o),
  .burst_valid_o (burst_valid_o),
  .burst_ready_i (burst_ready_i),
  .burst_addr_o  (burst_addr_o),
  .burst_len_o   (burst_len_o)
);

// File: tb/cmd_walker_test.sv
module cmd_walker_test;
  localparam int BB   = 16;
  localparam int BL_W = $clog2(BB) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start_i = 1'b0;
  logic [4:0]  slot_i = '0;
  logic [63:0] list_base_i = '0;
  logic        busy_o, done_o, err_o;
  logic [47:0] lba_o;
  logic        mem_req_o, mem_we_o, mem_ack_i;
  logic [63:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;
  logic        seg_valid_o, seg_ready_i, seg_write_o;
  logic [63:0] seg_addr_o;
  logic [31:0] seg_len_o;
  logic        burst_valid_o, burst_ready_i, burst_write_o;
  logic [63:0] burst_addr_o;
  logic [BL_W-1:0] burst_len_o;

  cmd_walker #(.BURST_BYTES(BB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .slot_i(slot_i),
    .list_base_i(list_base_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .lba_o(lba_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .seg_valid_o(seg_valid_o), .seg_ready_i(seg_ready_i),
    .seg_addr_o(seg_addr_o), .seg_len_o(seg_len_o), .seg_write_o(seg_write_o),
    .burst_valid_o(burst_valid_o), .burst_ready_i(burst_ready_i),
    .burst_addr_o(burst_addr_o), .burst_len_o(burst_len_o),
    .burst_write_o(burst_write_o)
  );

  // word memory, 16 KB
  logic [31:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i   <= 1'b1;
      mem_rdata_i <= mem[mem_addr_o[13:2]];
      if (mem_we_o) mem[mem_addr_o[13:2]] <= mem_wdata_o;
    end else begin
      mem_ack_i <= 1'b0;
    end
  end
  initial begin mem_ack_i = 1'b0; mem_rdata_i = '0; end

  int cyc = 0;
  initial begin
    seg_ready_i = 1'b0; burst_ready_i = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      seg_ready_i   <= (cyc % 3) != 1;
      burst_ready_i <= (cyc % 4) != 2;
    end
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected segment list
  logic [63:0] exp_addr [0:255];
  int          exp_len  [0:255];
  int          exp_n;
  bit          exp_wr;
  logic [31:0] exp_sum;
  int          seg_cnt, burst_bad;
  logic [63:0] cur_addr;
  int          cur_rem;

  always @(negedge clk) begin
    if (rst_n && seg_valid_o && seg_ready_i) begin
      if (seg_cnt < exp_n)
        chk(seg_addr_o == exp_addr[seg_cnt] && seg_len_o == 32'(exp_len[seg_cnt]) &&
            seg_write_o == exp_wr && cur_rem == 0, "R5/R2/R7", "segment",
            {seg_addr_o[31:0], seg_len_o}, {exp_addr[seg_cnt][31:0], 32'(exp_len[seg_cnt])});
      else
        chk(1'b0, "R3/R7", "unexpected segment", 64'(seg_cnt), 64'(exp_n));
      cur_addr = seg_addr_o;
      cur_rem  = int'(seg_len_o);
      seg_cnt++;
    end
    if (rst_n && burst_valid_o && burst_ready_i) begin
      int el;
      el = (cur_rem < BB) ? cur_rem : BB;
      chk(burst_addr_o == cur_addr && int'(burst_len_o) == el && burst_write_o == exp_wr,
          "R6", "burst", {burst_addr_o[55:0], 8'(burst_len_o)}, {cur_addr[55:0], 8'(el)});
      cur_addr = cur_addr + 64'(el);
      cur_rem  = cur_rem - el;
    end
  end

  function automatic int len_of(input int seed, input int i);
    if (seed == 0) return i * BB;
    return (seed + i * 13) % 53;
  endfunction

  task automatic prep(input int slot, input logic [63:0] base, input bit wr, input int nbuf,
                      input logic [31:0] tbl, input logic [47:0] lba, input int seed);
    logic [31:0] d;
    d = base[31:0] & ~32'hF;
    d = d + 32'(slot * 16);
    mem[d[13:2]]       = {16'(nbuf), 8'h3C, wr ? 8'hC5 : 8'h85};
    mem[d[13:2] + 1]   = 32'hDEADBEEF;
    mem[d[13:2] + 2]   = tbl;
    mem[d[13:2] + 3]   = 32'h0;
    mem[tbl[13:2]]     = 32'h12345678;
    mem[tbl[13:2] + 1] = {8'hAA, lba[23:0]};
    mem[tbl[13:2] + 2] = {8'h55, lba[47:24]};
    exp_sum = '0;
    exp_wr  = wr;
    exp_n   = (nbuf == 0 || nbuf > 248) ? 0 : nbuf;
    for (int i = 0; i < exp_n; i++) begin
      logic [31:0] b;
      b = tbl + 32'd128 + 32'(i * 16);
      exp_addr[i] = {32'h10 + 32'(i), 32'h8000_0003 + 32'(i * 256)};
      exp_len[i]  = len_of(seed, i);
      exp_sum     = exp_sum + 32'(exp_len[i]);
      mem[b[13:2]]     = exp_addr[i][31:0];
      mem[b[13:2] + 1] = exp_addr[i][63:32];
      mem[b[13:2] + 2] = 32'hFFFF_FFFF;
      mem[b[13:2] + 3] = 32'(exp_len[i]);
    end
  endtask

  task automatic run(input int slot, input logic [63:0] base, input bit wr, input int nbuf,
                     input logic [31:0] tbl, input logic [47:0] lba, input int seed,
                     input bit poke);
    logic [31:0] d;
    int n;
    bit abort;
    abort = (nbuf == 0 || nbuf > 248);
    prep(slot, base, wr, nbuf, tbl, lba, seed);
    seg_cnt = 0; cur_rem = 0;
    @(negedge clk);
    start_i = 1'b1; slot_i = 5'(slot); list_base_i = base;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", 64'(busy_o), 64'd1);
    if (poke) begin
      repeat (4) @(negedge clk);
      start_i = 1'b1; slot_i = 5'(slot ^ 1);
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R9", "done reached", 64'(n), 64'd0);
    chk(err_o == abort, "R3", "error flag", 64'(err_o), 64'(abort));
    chk(seg_cnt == exp_n && cur_rem == 0, "R7", "segments completed",
        64'(seg_cnt), 64'(exp_n));
    d = (base[31:0] & ~32'hF) + 32'(slot * 16);
    if (abort) begin
      chk(mem[d[13:2] + 1] == 32'hDEADBEEF, "R3", "no write-back",
          64'(mem[d[13:2] + 1]), 64'hDEADBEEF);
    end else begin
      chk(mem[d[13:2] + 1] == exp_sum, "R8", "write-back sum",
          64'(mem[d[13:2] + 1]), 64'(exp_sum));
      chk(lba_o == lba, "R4", "block address", 64'(lba_o), 64'(lba));
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R9", "done single pulse", {62'd0, done_o, busy_o}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !seg_valid_o && !burst_valid_o, "R9",
        "reset state", {59'd0, busy_o, done_o, mem_req_o, seg_valid_o, burst_valid_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2: single buffer read, slot 0
    run(0, 64'h100, 1'b0, 1, 32'h1000, 48'hA1B2C3D4E5F6, 5, 1'b0);
    // R1: low base bits ignored, write direction, exact multiples incl. zero length
    run(5, 64'h10F, 1'b1, 4, 32'h2000, 48'h0123456789AB, 0, 1'b0);
    // R9: ignored start while busy
    run(31, 64'h100, 1'b0, 4, 32'h1000, 48'hFEDCBA987654, 11, 1'b1);
    // near-exhaustive sweep of count and direction
    for (int nb = 1; nb <= 6; nb++)
      for (int w = 0; w < 2; w++)
        run((nb * 5 + w) % 32, 64'h100, w[0], nb, 32'h1000,
            48'h111111111111 * 48'(nb), nb * 3 + w, 1'b0);
    // R3: abort limits
    run(7, 64'h100, 1'b1, 0, 32'h1000, 48'h1, 1, 1'b0);
    run(8, 64'h100, 1'b0, 249, 32'h1000, 48'h2, 1, 1'b0);
    // R3: largest legal count
    run(2, 64'h100, 1'b1, 248, 32'h2000, 48'h800000000001, 3, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule